// File: doc/BRIEF.md
# Serial Management Frame Master

This block drives the two-wire PHY management bus from a single 32-bit frame register. Software loads the register through a write strobe. The block then sends a run of high preamble bits, followed by the 32 register bits, most significant bit first. The bus clock is produced by dividing the system clock. The block does not check the frame fields. Whatever sits in the start, opcode, turnaround and address fields goes out on the wire unchanged, so non-compliant frames are sent as written.

During a frame the register rotates in place, one position per bit, so a read of the register returns an intermediate value. On a write frame, 32 rotations bring back the exact image that software wrote. On a read frame, the block stops driving the data line from the second turnaround bit onward. It samples the PHY's 16 data bits and rotates them into the low half of the register. At the end of every frame, busy drops and a one-cycle interrupt pulse is raised.

Top module: `mdio_frame_ctrl`

## Requirements
- R1: After reset, busy, irq and mdc are 0, mdio_oe and mdio_o are 1, and rd_data is 0.
- R2: A wr_en pulse while idle loads wr_data into the register and sets busy in the next cycle. rd_data then shows the written value.
- R3: The divider value is taken from mdc_div when a frame starts, and any value below 2 is treated as 2. Each mdc period lasts that many system clocks: low for (div+1)/2 cycles, then high for the rest. Changing mdc_div during a frame has no effect on that frame.
- R4: Each frame begins with 32 mdc periods in which mdio is driven high.
- R5: After the preamble, the register is sent MSB first, one bit per mdc period, with each bit changing on a falling mdc edge. The layout is: start bits 31:30, opcode 29:28, PHY address 27:23, register address 22:18, turnaround 17:16, data 15:0. No field is altered or checked.
- R6: Register bit 29 selects a read frame (1) or a write frame (0). On a read frame, mdio_oe is 0 from register bit 16 (the second turnaround bit) through bit 0. A write frame drives all 32 bits.
- R7: On a read frame, mdio_i is sampled on each rising mdc edge of the 16 data bits, first sample into bit 15. At the end of the frame, bits 15:0 hold the sampled value and bits 31:16 hold their written value.
- R8: At the end of a write frame, rd_data equals exactly the written value.
- R9: A frame lasts 64 mdc periods. busy falls and irq pulses high for one cycle in the same cycle, 64*div clocks after the starting write.
- R10: A wr_en pulse during a frame overwrites the register at once. The frame's timing is unchanged, and no new frame is started.
- R11: When idle, mdc is low and mdio is driven high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mdc_div | input | DIVW | Divide ratio of mdc, sampled at frame start |
| wr_en | input | 1 | Frame register write strobe |
| wr_data | input | 32 | Frame register write value |
| rd_data | output | 32 | Frame register contents |
| busy | output | 1 | Frame in progress |
| irq | output | 1 | One-cycle frame completion pulse |
| mdc | output | 1 | Management bus clock |
| mdio_i | input | 1 | Data line input |
| mdio_o | output | 1 | Data line output value |
| mdio_oe | output | 1 | Data line output enable |

## Verification
A wrong bit counter or divider state shows up within one mdc period, either as a misplaced mdc edge or as a bit on mdio that differs from the expected frame position. A bad rotation or capture stays hidden while busy is high. It appears at the end of the frame, when rd_data fails to match the written image or its read-modified version. The bench therefore compares mdc, mdio and busy on every clock, and compares the register value in the first idle cycle.

// File: rtl/mdio_frame_ctrl.sv
module mdio_frame_ctrl #(
  parameter int DIVW    = 8,
  parameter int PRE_LEN = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [DIVW-1:0] mdc_div,
  input  logic            wr_en,
  input  logic [31:0]     wr_data,
  output logic [31:0]     rd_data,
  output logic            busy,
  output logic            irq,
  output logic            mdc,
  input  logic            mdio_i,
  output logic            mdio_o,
  output logic            mdio_oe
);
  localparam int FRAME_LEN = 32;
  localparam int TOTAL     = PRE_LEN + FRAME_LEN;
  localparam int BW        = $clog2(TOTAL);
  localparam int DATA_POS  = 16;

  logic [31:0]     frame_q;
  logic            busy_q, irq_q, mdc_q, smp_q, rd_q;
  logic [DIVW-1:0] div_q, cnt_q;
  logic [BW-1:0]   bit_q;

  logic [DIVW-1:0] div_eff;
  logic [DIVW:0]   lo_len;
  logic            in_pre, rise, fall, cap;
  logic [BW-1:0]   dat_idx;

  assign div_eff = (mdc_div < DIVW'(2)) ? DIVW'(2) : mdc_div;
  assign lo_len  = ({1'b0, div_q} + 1'b1) >> 1;
  assign in_pre  = bit_q < BW'(PRE_LEN);
  assign dat_idx = bit_q - BW'(PRE_LEN);
  assign rise    = busy_q && !mdc_q && ({1'b0, cnt_q} == lo_len - 1'b1);
  assign fall    = busy_q && ({1'b0, cnt_q} == {1'b0, div_q} - 1'b1);
  assign cap     = rd_q && !in_pre && (dat_idx >= BW'(DATA_POS));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frame_q <= '0;
      busy_q  <= 1'b0;
      irq_q   <= 1'b0;
      mdc_q   <= 1'b0;
      smp_q   <= 1'b0;
      rd_q    <= 1'b0;
      div_q   <= DIVW'(2);
      cnt_q   <= '0;
      bit_q   <= '0;
    end else begin
      irq_q <= 1'b0;
      if (busy_q) begin
        if (rise) begin
          mdc_q <= 1'b1;
          smp_q <= mdio_i;
        end
        if (fall) begin
          mdc_q <= 1'b0;
          cnt_q <= '0;
          if (!in_pre)
            frame_q <= {frame_q[30:0], cap ? smp_q : frame_q[31]};
          if (bit_q == BW'(TOTAL - 1)) begin
            busy_q <= 1'b0;
            irq_q  <= 1'b1;
            bit_q  <= '0;
          end else begin
            bit_q <= bit_q + 1'b1;
          end
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
      if (wr_en) begin
        frame_q <= wr_data;
        if (!busy_q) begin
          busy_q <= 1'b1;
          cnt_q  <= '0;
          bit_q  <= '0;
          mdc_q  <= 1'b0;
          div_q  <= div_eff;
          rd_q   <= wr_data[29];
        end
      end
    end
  end

  assign rd_data = frame_q;
  assign busy    = busy_q;
  assign irq     = irq_q;
  assign mdc     = mdc_q;
  assign mdio_o  = (!busy_q || in_pre) ? 1'b1 : frame_q[31];
  assign mdio_oe = !(busy_q && rd_q && !in_pre && (dat_idx >= BW'(DATA_POS - 1)));

  AST_IRQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq); // R9
  AST_IRQ_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (!busy && $past(busy))); // R9
  AST_START_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !busy) |=> (busy && rd_data == $past(wr_data))); // R2
  AST_MDC_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mdc && mdio_oe && mdio_o)); // R11
  AST_MDIO_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && !$past(wr_en) && !$fell(mdc)) |-> $stable(mdio_o)); // R5
  AST_RELEASE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    !mdio_oe |-> busy); // R6
endmodule

// File: tb/mdio_frame_ctrl_tb_top.sv
module mdio_frame_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DIVW = 8;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [DIVW-1:0] mdc_div = 8'd4;
  logic            wr_en = 1'b0;
  logic [31:0]     wr_data = '0;
  logic [31:0]     rd_data;
  logic            busy, irq, mdc, mdio_i, mdio_o, mdio_oe;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  logic run_chk = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mdio_frame_ctrl #(.DIVW(DIVW), .PRE_LEN(32)) dut_i (
    .clk(clk), .rst_n(rst_n), .mdc_div(mdc_div), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .busy(busy), .irq(irq), .mdc(mdc), .mdio_i(mdio_i),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe));

  // reference model: cycle count since the starting write
  logic        m_act = 1'b0, m_irq = 1'b0, m_rd = 1'b0, m_corrupt = 1'b0;
  int          m_t = 0, m_div = 2;
  logic [31:0] m_img = '0, m_final = '0;
  logic [15:0] phy_data = 16'h0000;

  function automatic logic phy_drive(int t, int d, logic [15:0] pd);
    int j;
    j = t / d - 32;
    if (j >= 16 && j <= 31) return pd[31 - j];
    return 1'b1;
  endfunction

  assign mdio_i = mdio_oe ? mdio_o : phy_drive(m_t, m_div, phy_data);

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_act <= 1'b0; m_irq <= 1'b0; m_t <= 0; m_final <= '0; m_corrupt <= 1'b0;
    end else begin
      m_irq <= 1'b0;
      if (m_act) begin
        if (m_t == 64 * m_div - 1) begin
          m_act <= 1'b0;
          m_irq <= 1'b1;
          if (!m_corrupt) m_final <= m_rd ? {m_img[31:16], phy_data} : m_img;
        end else begin
          m_t <= m_t + 1;
        end
      end
      if (wr_en) begin
        if (m_act) begin
          m_corrupt <= 1'b1;
        end else begin
          m_act <= 1'b1; m_t <= 0;
          m_div <= (mdc_div < 2) ? 2 : int'(mdc_div);
          m_img <= wr_data; m_rd <= wr_data[29]; m_corrupt <= 1'b0;
          m_final <= wr_data;
        end
      end
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h at cycle %0d", tag, act, exp, cycles);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && run_chk) begin
      int b, j;
      logic eo, eoe;
      b = m_t / m_div;
      j = b - 32;
      chk("R9 busy", 32'(busy), 32'(m_act));
      chk("R9 irq", 32'(irq), 32'(m_irq));
      chk("R3 mdc", 32'(mdc), 32'(m_act && ((m_t % m_div) >= (m_div + 1) / 2)));
      if (!m_act) begin
        chk("R11 idle mdio_o", 32'(mdio_o), 32'd1);
        chk("R11 idle mdio_oe", 32'(mdio_oe), 32'd1);
        if (!m_corrupt) chk(m_rd ? "R7 read result" : "R8 write restore", rd_data, m_final);
      end else if (!m_corrupt) begin
        eo  = (b < 32) ? 1'b1 : m_img[31 - j];
        eoe = !(b >= 32 && m_rd && j >= 15);
        chk((b < 32) ? "R4 preamble" : "R5 frame bit", 32'(mdio_o), 32'(eo));
        chk("R6 output enable", 32'(mdio_oe), 32'(eoe));
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      $display("FAIL R9 watchdog actual busy=%0d expected finished run", busy);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic start_frame(logic [31:0] v, logic [DIVW-1:0] d, logic [15:0] pd);
    @(negedge clk);
    phy_data = pd; mdc_div = d; wr_data = v; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
    chk("R2 busy after write", 32'(busy), 32'd1);
    chk("R2 register loaded", rd_data, v);
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 busy", 32'(busy), 0);
    chk("R1 irq", 32'(irq), 0);
    chk("R1 mdc", 32'(mdc), 0);
    chk("R1 mdio_oe", 32'(mdio_oe), 1);
    chk("R1 mdio_o", 32'(mdio_o), 1);
    chk("R1 rd_data", rd_data, 0);
    rst_n = 1'b1;
    run_chk = 1'b1;
    repeat (2) @(negedge clk);

    // R8 compliant write frame
    start_frame({2'b01, 2'b01, 5'd3, 5'd17, 2'b10, 16'hBEEF}, 8'd4, 16'h0);
    wait_idle();
    // R7 compliant read frame, smallest divider
    start_frame({2'b01, 2'b10, 5'd31, 5'd0, 2'b10, 16'h1234}, 8'd2, 16'hA5C3);
    wait_idle();
    // R7 non-compliant read, odd divider, divider input changed mid-frame (R3)
    start_frame({2'b10, 2'b11, 5'd21, 5'd10, 2'b01, 16'hFFFF}, 8'd5, 16'h0F31);
    repeat (40) @(negedge clk);
    mdc_div = 8'd9;
    wait_idle();
    // R5 non-compliant write, all fields odd patterns; R3 divider 0 clamps to 2
    start_frame({2'b00, 2'b00, 5'd0, 5'd31, 2'b11, 16'h8001}, 8'd0, 16'h0);
    wait_idle();
    // R3 divider 3, read frame with alternating phy data
    start_frame(32'h6ABC_5555, 8'd3, 16'h5AA5);
    wait_idle();
    // R10 write during frame overwrites register, timing unchanged
    start_frame(32'h5002_0000, 8'd4, 16'h0);
    repeat (100) @(negedge clk);
    mdc_div = 8'd7; wr_data = 32'hDEAD_BEEF; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
    chk("R10 overwrite visible", rd_data, 32'hDEAD_BEEF);
    chk("R10 still busy", 32'(busy), 1);
    wait_idle();
    // back-to-back frame after the corrupted one
    start_frame(32'h5FFF_0F0F, 8'd6, 16'h0);
    wait_idle();

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule